// File: doc/BRIEF.md
# Serial Command Link with Display Memory for a Multiplexed LED Driver

This block is the host side of a multiplexed LED panel driver. A controller talks to it over three wires: a strobe that frames each transfer, a serial clock, and a data line. Bits travel least significant first. The first byte after the strobe falls is always a command. Any bytes that follow in the same frame are display data or, after a key-read command, key bytes that the block shifts back out.

The commands fall into four classes. They pick the grid/segment arrangement, choose between writing and key reading, load the memory pointer, and switch the display on or off with a brightness code. Display data goes into a 14-byte memory. The pointer can step forward after every byte or stay fixed. Writes stop while the pointer sits beyond the last valid location. The scanner reads the memory through its own synchronous port and takes the arrangement, on/off and brightness straight from registered outputs.

All serial inputs are taken as already synchronous to `clk`. Each half period of the serial clock must span at least two `clk` cycles.

Top module: `ledc_host_link`

## Requirements
- R1: After reset: arrangement code is 3 (7 grids / 10 segments), display off, brightness code 0 (narrowest pulse), pointer at 0, write mode with pointer stepping, and `ser_dout` released (1).
- R2: A data bit is taken on each rising edge of `ser_clk` while `ser_stb` is low. Bytes arrive b0 first. Edges of `ser_clk` while `ser_stb` is high change nothing.
- R3: The first complete byte of a frame is a command. Its class is set by b7:b6: 00 arrangement, 01 transfer setup, 10 display control, 11 pointer load.
- R4: If `ser_stb` rises before a byte is complete, the partial byte is dropped. The next frame starts again with a command.
- R5: An arrangement command with b5:b2 = 0 loads b1:b0 into `disp_mode` (00 = 4/13, 01 = 5/12, 10 = 6/11, 11 = 7/10). If the code differs from the current one, the display is switched off. A class-00 byte with any of b5:b2 set is ignored.
- R6: An arrangement command equal to the current code has no effect, and an active display stays on.
- R7: A display control command sets `disp_on` from b3 and `disp_dim` from b2:b0. 80h gives off with code 0.
- R8: A pointer-load command takes its pointer from b3:b0. Each data byte in write mode goes into the memory at the pointer, and the pointer then advances by one.
- R9: A transfer setup command (b5:b4 = 0) selects a fixed pointer with b2 = 1, so successive data bytes overwrite one location.
- R10: When the pointer is 0Eh or higher, data bytes are neither stored nor counted. Advancing past 0Dh therefore blocks further writes until a valid pointer is loaded.
- R11: A transfer setup command with b1 = 1 selects key read. On each falling serial clock edge after that command, `ser_dout` presents the next bit of `key_in`, index 0 first (byte k, bit i is index 8k+i). In key-read mode, data bytes do not write the memory. `ser_dout` returns to 1 when the strobe goes high.
- R12: `ram_rdata` shows the memory byte at `ram_raddr` one `clk` cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_stb | input | 1 | Frame strobe, active low |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Key data out, 1 = released (open-drain style) |
| key_in | input | KEY_BYTES*8 | Key matrix state, snapshotted at a key-read command |
| ram_raddr | input | 4 | Scanner read address |
| ram_rdata | output | DW | Scanner read data, one cycle latency |
| disp_mode | output | 2 | Grid/segment arrangement code |
| disp_on | output | 1 | Display enable |
| disp_dim | output | 3 | Brightness (pulse width) code |

## Verification
Directed frames cover every command class. They include a repeated arrangement code against a changed one, a class-00 byte with reserved bits set, fixed against stepping pointers, a pointer load beyond the memory, a run that walks past the last location, and strobes that cut a byte short in both the command and the data position. Between frames the bench toggles the serial clock with the strobe high. A following command that decodes exactly shows that those toggles and the aborted fragments left no bits behind. Random frames then mix pointer loads, burst lengths, arrangement and control codes, and are compared against a bench model of memory and registers. A key read with a random pattern shows the bit order and that read mode suppresses writes.

// File: rtl/ledc_pkg.sv
package ledc_pkg;
  localparam int ADDR_W = 4;  // width of the pointer field in a pointer-load command

  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_XFER = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_ADDR = 2'b11
  } cmd_class_e;
endpackage

// File: rtl/ledc_serial_port.sv
module ledc_serial_port #(
  parameter int KEY_BITS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk,
  input  logic                ser_stb,
  input  logic                ser_din,
  input  logic                tx_start,
  input  logic [KEY_BITS-1:0] key_in,
  output logic                byte_v,
  output logic [7:0]          byte_d,
  output logic                byte_is_cmd,
  output logic                ser_dout
);
  localparam int KW = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1;

  logic                sclk_q;
  logic [2:0]          bit_cnt;
  logic [6:0]          sh;
  logic                first_q;
  logic                tx_act;
  logic [KW-1:0]       tx_idx;
  logic [KEY_BITS-1:0] snap;
  logic                rise, fall;

  assign rise = ser_clk & ~sclk_q & ~ser_stb;
  assign fall = ~ser_clk & sclk_q & ~ser_stb;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b1;
    else     sclk_q <= ser_clk;
  end

  always_ff @(posedge clk) begin
    if (rst || ser_stb) begin
      bit_cnt     <= '0;
      sh          <= '0;
      first_q     <= 1'b1;
      byte_v      <= 1'b0;
      byte_is_cmd <= 1'b0;
      tx_act      <= 1'b0;
      tx_idx      <= '0;
      ser_dout    <= 1'b1;
      if (rst) begin
        byte_d <= '0;
        snap   <= '0;
      end
    end else begin
      byte_v <= 1'b0;
      if (rise) begin
        sh      <= {ser_din, sh[6:1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_v      <= 1'b1;
          byte_d      <= {ser_din, sh};
          byte_is_cmd <= first_q;
          first_q     <= 1'b0;
        end
      end
      if (tx_start) begin
        tx_act <= 1'b1;
        tx_idx <= '0;
        snap   <= key_in;
      end else if (tx_act && fall) begin
        ser_dout <= snap[tx_idx];
        tx_idx   <= (tx_idx == KW'(KEY_BITS-1)) ? '0 : tx_idx + KW'(1);
      end
    end
  end

  // R4: a high strobe leaves no partial byte and no completion behind
  a_r4_strobe_clears: assert property (@(posedge clk) disable iff (rst)
    ser_stb |=> (bit_cnt == 3'd0) && !byte_v);
  // R2: bytes only complete inside a frame
  a_r2_byte_in_frame: assert property (@(posedge clk) disable iff (rst)
    byte_v |-> $past(!ser_stb));
endmodule

// File: rtl/ledc_cmd_ctrl.sv
module ledc_cmd_ctrl #(
  parameter int DEPTH = 14,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        byte_v,
  input  logic [7:0]                  byte_d,
  input  logic                        byte_is_cmd,
  output logic                        wr_en,
  output logic [ledc_pkg::ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]               wr_data,
  output logic                        tx_start,
  output logic [1:0]                  disp_mode,
  output logic                        disp_on,
  output logic [2:0]                  disp_dim
);
  import ledc_pkg::*;

  cmd_class_e         cls;
  logic               cmd_v;
  logic               rd_q, fix_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               addr_ok;

  assign cls     = cmd_class_e'(byte_d[7:6]);
  assign cmd_v   = byte_v & byte_is_cmd;
  assign addr_ok = (32'(addr_q) < DEPTH);

  always_comb begin
    wr_en    = byte_v & ~byte_is_cmd & ~rd_q & addr_ok;
    wr_addr  = addr_q;
    wr_data  = DW'(byte_d);
    tx_start = cmd_v & (cls == CLS_XFER) & (byte_d[5:4] == 2'b00) & byte_d[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_mode <= 2'b11;
      disp_on   <= 1'b0;
      disp_dim  <= 3'd0;
      rd_q      <= 1'b0;
      fix_q     <= 1'b0;
      addr_q    <= '0;
    end else if (cmd_v) begin
      unique case (cls)
        CLS_MODE: if (byte_d[5:2] == 4'd0 && byte_d[1:0] != disp_mode) begin
          disp_mode <= byte_d[1:0];
          disp_on   <= 1'b0;
        end
        CLS_XFER: if (byte_d[5:4] == 2'b00) begin
          rd_q  <= byte_d[1];
          fix_q <= byte_d[2];
        end
        CLS_CTRL: begin
          disp_on  <= byte_d[3];
          disp_dim <= byte_d[2:0];
        end
        CLS_ADDR: addr_q <= byte_d[ADDR_W-1:0];
        default: ;
      endcase
    end else if (wr_en && !fix_q) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  // R5: any arrangement change leaves the display blanked
  a_r5_change_blanks: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_mode) |-> !disp_on);
  // R6: repeating the current arrangement keeps the enable
  a_r6_same_mode_keeps: assert property (@(posedge clk) disable iff (rst)
    (cmd_v && cls == CLS_MODE && byte_d[1:0] == disp_mode) |=> $stable(disp_on));
  // R7: brightness moves only on a received command
  a_r7_dim_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    !cmd_v |=> $stable(disp_dim));
endmodule

// File: rtl/ledc_disp_ram.sv
module ledc_disp_ram #(
  parameter int DEPTH = 14,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R10: no store ever lands outside the valid locations
  a_r10_write_in_range: assert property (@(posedge clk) disable iff (rst)
    we |-> (32'(waddr) < DEPTH));
endmodule

// File: rtl/ledc_host_link.sv
module ledc_host_link #(
  parameter int DEPTH     = 14,
  parameter int DW        = 8,
  parameter int KEY_BYTES = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ser_clk,
  input  logic                   ser_stb,
  input  logic                   ser_din,
  output logic                   ser_dout,
  input  logic [KEY_BYTES*8-1:0] key_in,
  input  logic [3:0]             ram_raddr,
  output logic [DW-1:0]          ram_rdata,
  output logic [1:0]             disp_mode,
  output logic                   disp_on,
  output logic [2:0]             disp_dim
);
  localparam int KEY_BITS = KEY_BYTES * 8;
  localparam int AW       = ledc_pkg::ADDR_W;

  logic          byte_v, byte_is_cmd, tx_start, wr_en;
  logic [7:0]    byte_d;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  ledc_serial_port #(.KEY_BITS(KEY_BITS)) u_port (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_stb(ser_stb), .ser_din(ser_din),
    .tx_start(tx_start), .key_in(key_in), .byte_v(byte_v), .byte_d(byte_d),
    .byte_is_cmd(byte_is_cmd), .ser_dout(ser_dout)
  );

  ledc_cmd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .byte_v(byte_v), .byte_d(byte_d), .byte_is_cmd(byte_is_cmd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tx_start(tx_start),
    .disp_mode(disp_mode), .disp_on(disp_on), .disp_dim(disp_dim)
  );

  ledc_disp_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  // R11: the key output is released one cycle after the strobe is high
  a_r11_dout_released: assert property (@(posedge clk) disable iff (rst)
    ser_stb |=> ser_dout);
endmodule

// File: tb/ledc_host_link_tb.sv
module ledc_host_link_tb;
  localparam int DEPTH = 14;
  localparam int KB    = 5;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b1, ser_stb = 1'b1, ser_din = 1'b0;
  logic ser_dout;
  logic [KB*8-1:0] key_in = '0;
  logic [3:0] ram_raddr = '0;
  logic [7:0] ram_rdata;
  logic [1:0] disp_mode;
  logic disp_on;
  logic [2:0] disp_dim;

  always #10 clk = ~clk;

  ledc_host_link #(.DEPTH(DEPTH), .DW(8), .KEY_BYTES(KB)) u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_stb(ser_stb), .ser_din(ser_din),
    .ser_dout(ser_dout), .key_in(key_in), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .disp_mode(disp_mode), .disp_on(disp_on), .disp_dim(disp_dim)
  );

  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  // bench model
  logic [7:0] mm [DEPTH];
  logic [1:0] m_mode;
  logic m_on, m_rd, m_fix, first;
  logic [2:0] m_dim;
  logic [3:0] m_addr;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_byte(input logic [7:0] b, input logic cmd);
    if (cmd) begin
      case (b[7:6])
        2'b00: if (b[5:2] == 4'd0 && b[1:0] != m_mode) begin m_mode = b[1:0]; m_on = 1'b0; end
        2'b01: if (b[5:4] == 2'b00) begin m_rd = b[1]; m_fix = b[2]; end
        2'b10: begin m_on = b[3]; m_dim = b[2:0]; end
        default: m_addr = b[3:0];
      endcase
    end else if (!m_rd && m_addr < 4'(DEPTH)) begin
      mm[m_addr] = b;
      if (!m_fix) m_addr = m_addr + 4'd1;
    end
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    ser_clk = 1'b0; ser_din = b; wait_clk(HALF);
    ser_clk = 1'b1; wait_clk(HALF);
  endtask

  task automatic frame_begin();
    ser_stb = 1'b0; first = 1'b1; wait_clk(HALF);
  endtask

  task automatic frame_end();
    wait_clk(HALF); ser_stb = 1'b1; wait_clk(2*HALF);
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
    model_byte(b, first);
    first = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] r);
    for (int i = 0; i < 8; i++) begin
      ser_clk = 1'b0; wait_clk(HALF);
      r[i] = ser_dout;
      ser_clk = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic cmd_frame(input logic [7:0] c);
    frame_begin(); send(c); frame_end();
  endtask

  task automatic check_regs(input string req);
    check(req, {62'd0, disp_mode}, {62'd0, m_mode});
    check(req, {63'd0, disp_on}, {63'd0, m_on});
    check(req, {61'd0, disp_dim}, {61'd0, m_dim});
  endtask

  task automatic check_ram(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      ram_raddr = 4'(a);
      @(negedge clk);  // one rising edge later: R12 latency
      check(req, {56'd0, ram_rdata}, {56'd0, mm[a]});
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 190000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    m_mode = 2'b11; m_on = 1'b0; m_dim = 3'd0; m_addr = 4'd0; m_rd = 1'b0; m_fix = 1'b0;
    for (int a = 0; a < DEPTH; a++) mm[a] = 8'h00;
    wait_clk(4); rst = 1'b0; wait_clk(2);

    // R1: reset values
    check("R1 reset", {60'd0, disp_mode, disp_on, ser_dout}, {60'd0, 2'b11, 1'b0, 1'b1});
    check("R1 reset dim", {61'd0, disp_dim}, 64'd0);

    // R1/R8: default write mode, pointer at 0 stepping; fill all locations
    frame_begin(); send(8'hC0);
    for (int a = 0; a < DEPTH; a++) send(8'(8'h11 * (a + 1)));
    frame_end();
    check_ram("R8 fill from pointer 0");

    // R7 / R3: control commands
    cmd_frame(8'h8F); check_regs("R7 on dim7");
    cmd_frame(8'h80); check_regs("R7 80h off");
    cmd_frame(8'h8B); check_regs("R7 on dim3");
    // R6: same arrangement keeps display on
    cmd_frame(8'h03); check_regs("R6 same mode");
    check("R6 still on", {63'd0, disp_on}, 64'd1);
    // R5: change blanks, reserved bits ignored
    cmd_frame(8'h01); check_regs("R5 change");
    check("R5 blanked", {63'd0, disp_on}, 64'd0);
    cmd_frame(8'h8C); cmd_frame(8'h06); check_regs("R5 reserved ignored");
    check("R5 mode kept", {62'd0, disp_mode}, 64'd1);

    // R9: fixed pointer
    cmd_frame(8'h44);
    frame_begin(); send(8'hC5); send(8'hA1); send(8'hB2); send(8'hC3); frame_end();
    check_ram("R9 fixed pointer");
    cmd_frame(8'h40);

    // R10: invalid pointer and walking past the end
    frame_begin(); send(8'hCE); send(8'h5A); send(8'h6B); frame_end();
    frame_begin(); send(8'hCC); send(8'hE1); send(8'hE2); send(8'hE3); frame_end();
    check_ram("R10 blocked writes");

    // R4: abort inside the command byte, then inside a data byte
    frame_begin(); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); frame_end();
    cmd_frame(8'h8A); check_regs("R4 abort in command");
    frame_begin(); send(8'hC2); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); frame_end();
    check_ram("R4 abort in data");

    // R2: clock toggles with strobe high are ignored
    for (int i = 0; i < 11; i++) begin ser_din = 1'(i); ser_clk = 1'b0; wait_clk(HALF); ser_clk = 1'b1; wait_clk(HALF); end
    check_regs("R2 idle toggles");
    cmd_frame(8'h85); check_regs("R2 LSB-first decode");

    // R11: key read
    key_in = {8'($urandom), $urandom};
    frame_begin(); send(8'h42);
    for (int k = 0; k < KB; k++) begin
      read_byte(r);
      check("R11 key byte", {56'd0, r}, {56'd0, key_in[8*k +: 8]});
    end
    frame_end();
    check("R11 released", {63'd0, ser_dout}, 64'd1);
    frame_begin(); send(8'hC0); send(8'h99); frame_end();
    check_ram("R11 no write in read mode");
    cmd_frame(8'h40);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        int n;
        cmd_frame({5'b01000, 1'($urandom), 2'b00});
        n = 1 + int'($urandom % 4);
        frame_begin(); send({4'hC, 4'($urandom)});
        for (int j = 0; j < n; j++) send(8'($urandom));
        frame_end();
      end else if (op == 1) begin
        cmd_frame({4'h8, 4'($urandom)});
      end else begin
        cmd_frame({6'd0, 2'($urandom)});
      end
      check_regs("R3 random command");
    end
    check_ram("R8 random bursts");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule